// File: doc/BRIEF.md
# Parallel-Bus Converter Sequencer

This block is the digital control core of a 12-bit successive-approximation converter with six multiplexed analog inputs. A host on a shared microprocessor bus reaches it with a chip select and separate write and read strobes. Each write carries a control byte that picks the power and clock mode, how acquisition is timed, the input range and polarity, and the input channel. The block then tracks the input, either for a fixed number of clocks or until the host writes again. After that it runs a bit-by-bit search against an external comparator, pulls an active-low completion flag, and presents the 12-bit result when the host reads.

The analog parts (track/hold, trial DAC, reference and comparator) sit outside the block. They are driven through plain digital outputs: a track enable, the trial code, the channel and range selects and the power controls. The block samples one comparator bit back. The three-state bus is split into a host-driven input byte, a result word and an output enable that a pad ring turns into the shared lines. All three host strobes are asynchronous and are synchronised to the conversion clock before any edge is detected.

Top module: `adcseq_top`

## Requirements
- R1: The control byte on bus_in is decoded as bit 7 power-down select, bit 6 clock/power qualifier, bit 5 host-timed acquisition, bit 4 range span, bit 3 bipolar, bits 2..0 channel. An accepted byte shows its channel on ch_sel, bit 4 on rng_hi and bit 3 on bip_mode.
- R2: An accepted write with bit 7 = 0 and bit 5 = 0 raises trk_en for exactly ACQ_CYCLES (6) clocks. Conversion then starts, and trk_en and sar_active are never high together.
- R3: An accepted write with bit 7 = 0 and bit 5 = 1 raises trk_en and holds it until a later accepted write with bit 5 = 0. That write's fields are latched and conversion starts. Further writes with bit 5 = 1 keep tracking.
- R4: Conversion lasts exactly 12 clocks with sar_active high and tests one bit per clock, MSB first. dac_code shows the trial code, and cmp_in = 1 (input at or above the trial) keeps the bit, so the raw code equals the input level.
- R5: With bip_mode = 0 the result is the raw straight-binary code. With bip_mode = 1 it is two's complement, which is the raw code with bit 11 inverted.
- R6: int_n is 1 after reset and goes low once a conversion completes. It returns high on an accepted read or an accepted write.
- R7: With cs_n low, a falling rd_n drives the result on bus_out with bus_oe = 1, bit 11 as MSB. bus_oe returns to 0 after rd_n or cs_n rises.
- R8: While cs_n is high, write and read strobes have no effect (no control change, no acquisition, int_n unchanged) and bus_oe stays 0.
- R9: Bits 7..6 select the power mode: 00 normal with clk_internal = 0, 01 normal with clk_internal = 1, 10 standby (standby = 1), 11 full power-down (full_pd = 1). Codes 10 and 11 keep clk_internal unchanged and start no acquisition.
- R10: A write whose channel field is 6 or 7 is ignored as a whole: no field changes, no acquisition, int_n unchanged.
- R11: A write that arrives during timed acquisition or during conversion is ignored.
- R12: After reset int_n = 1, bus_oe = 0, trk_en = 0, sar_active = 0, ch_sel = 0, standby = 0, full_pd = 0 and clk_internal = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, rising edge acts |
| rd_n | input | 1 | Read strobe, falling edge acts |
| bus_in | input | 8 | Control byte driven by the host |
| cmp_in | input | 1 | Comparator: 1 when input is at or above dac_code |
| bus_out | output | 12 | Conversion result |
| bus_oe | output | 1 | Enable for the result onto the shared bus |
| int_n | output | 1 | Completion flag, active low |
| trk_en | output | 1 | Track/hold in track mode |
| sar_active | output | 1 | Conversion in progress |
| dac_code | output | 12 | Trial code for the external DAC |
| ch_sel | output | 3 | Selected input channel |
| bip_mode | output | 1 | Bipolar range selected |
| rng_hi | output | 1 | Larger span selected |
| clk_internal | output | 1 | Internal clock source selected |
| standby | output | 1 | Standby power-down |
| full_pd | output | 1 | Full power-down |

## Verification
The hardest case to reach is a write that lands inside a running conversion. The host cannot observe the sequencer's phase directly, and the strobe synchroniser adds latency. The bench issues a second write back to back after one that starts timed acquisition and spaces it so its synchronised rising edge falls within the 12 conversion clocks. It then checks that the channel and result still belong to the first byte. Host-timed acquisition is also held open across a long idle gap to show that tracking never ends on its own.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_TRK_INT = 2'd1,
    ST_TRK_EXT = 2'd2,
    ST_CONV    = 2'd3
  } seq_state_t;

  // Host-visible field order of the control byte (MSB first)
  typedef struct packed {
    logic       pd_sel;
    logic       pd_qual;
    logic       acq_host;
    logic       span_hi;
    logic       bipolar;
    logic [2:0] chan;
  } ctrl_byte_t;

endpackage

// File: rtl/adcseq_sync.sv
module adcseq_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= RST_VAL;
          else     stg[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= RST_VAL;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/adcseq_sar.sv
module adcseq_sar #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         cmp,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] code,
  output logic [W-1:0] dac
);

  logic [W-1:0] sar;
  logic [W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      sar  <= '0;
      mask <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sar  <= '0;
        mask <= {1'b1, {(W-1){1'b0}}};
        busy <= 1'b1;
      end else if (busy) begin
        if (cmp) sar <= sar | mask;
        mask <= mask >> 1;
        if (mask[0]) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign code = sar;
  assign dac  = busy ? (sar | mask) : '0;

endmodule

// File: rtl/adcseq_busport.sv
module adcseq_busport #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] raw,
  input  logic         bip,
  input  logic         cs_s,
  input  logic         rd_s,
  input  logic         rd_fall,
  output logic [W-1:0] data,
  output logic         oe
);

  logic [W-1:0] result;

  always_ff @(posedge clk) begin
    if (rst)       result <= '0;
    else if (load) result <= bip ? {~raw[W-1], raw[W-2:0]} : raw;
  end

  always_ff @(posedge clk) begin
    if (rst) oe <= 1'b0;
    else     oe <= ~cs_s & ~rd_s & (rd_fall | oe);
  end

  assign data = result;

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int NUM_CH     = 6,
  parameter int ACQ_CYCLES = 6,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [7:0]        bus_in,
  input  logic              cmp_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              int_n,
  output logic              trk_en,
  output logic              sar_active,
  output logic [DATA_W-1:0] dac_code,
  output logic [2:0]        ch_sel,
  output logic              bip_mode,
  output logic              rng_hi,
  output logic              clk_internal,
  output logic              standby,
  output logic              full_pd
);

  localparam int CTRL_W = $bits(ctrl_byte_t);
  localparam int SYN_W  = CTRL_W + 3;
  localparam int CNT_W  = $clog2(ACQ_CYCLES + 1);
  localparam logic [CNT_W-1:0] ACQ_LAST = CNT_W'(ACQ_CYCLES - 1);
  localparam logic [SYN_W-1:0] SYN_RST  = {3'b111, {CTRL_W{1'b0}}};

  // strobe and data synchronisation
  logic [SYN_W-1:0] syn;
  logic             cs_s, wr_s, rd_s, wr_d, rd_d;
  ctrl_byte_t       new_ctrl;

  adcseq_sync #(.W(SYN_W), .STAGES(SYNC_STG), .RST_VAL(SYN_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, wr_n, rd_n, bus_in}),
    .q   (syn)
  );

  assign cs_s     = syn[SYN_W-1];
  assign wr_s     = syn[SYN_W-2];
  assign rd_s     = syn[SYN_W-3];
  assign new_ctrl = ctrl_byte_t'(syn[CTRL_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_d <= 1'b1;
      rd_d <= 1'b1;
    end else begin
      wr_d <= wr_s;
      rd_d <= rd_s;
    end
  end

  logic wr_rise, rd_fall, ch_ok, accept;
  seq_state_t st, st_n;

  assign wr_rise = ~cs_s & wr_s & ~wr_d;
  assign rd_fall = ~cs_s & ~rd_s & rd_d;
  assign ch_ok   = (32'(new_ctrl.chan) < NUM_CH);
  assign accept  = wr_rise & ch_ok & ((st == ST_IDLE) | (st == ST_TRK_EXT));

  // sequencer
  logic [CNT_W-1:0] acq_cnt, cnt_n;
  logic             sar_go, sar_done;
  logic [DATA_W-1:0] sar_code;

  always_comb begin
    st_n   = st;
    cnt_n  = acq_cnt;
    sar_go = 1'b0;
    case (st)
      ST_IDLE: begin
        if (accept && !new_ctrl.pd_sel) begin
          if (new_ctrl.acq_host) begin
            st_n = ST_TRK_EXT;
          end else begin
            st_n  = ST_TRK_INT;
            cnt_n = '0;
          end
        end
      end
      ST_TRK_INT: begin
        if (acq_cnt == ACQ_LAST) begin
          st_n   = ST_CONV;
          sar_go = 1'b1;
        end else begin
          cnt_n = acq_cnt + 1'b1;
        end
      end
      ST_TRK_EXT: begin
        if (accept) begin
          if (new_ctrl.pd_sel) begin
            st_n = ST_IDLE;
          end else if (!new_ctrl.acq_host) begin
            st_n   = ST_CONV;
            sar_go = 1'b1;
          end
        end
      end
      ST_CONV: begin
        if (sar_done) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      acq_cnt <= '0;
    end else begin
      st      <= st_n;
      acq_cnt <= cnt_n;
    end
  end

  // latched control fields
  logic       pd_sel_q, pd_qual_q, span_q, bip_q, clk_int_q;
  logic [2:0] chan_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_sel_q  <= 1'b0;
      pd_qual_q <= 1'b0;
      span_q    <= 1'b0;
      bip_q     <= 1'b0;
      chan_q    <= '0;
      clk_int_q <= 1'b0;
    end else if (accept) begin
      pd_sel_q  <= new_ctrl.pd_sel;
      pd_qual_q <= new_ctrl.pd_qual;
      span_q    <= new_ctrl.span_hi;
      bip_q     <= new_ctrl.bipolar;
      chan_q    <= new_ctrl.chan;
      if (!new_ctrl.pd_sel) clk_int_q <= new_ctrl.pd_qual;
    end
  end

  // conversion engine
  logic conv_end;

  adcseq_sar #(.W(DATA_W)) u_sar (
    .clk   (clk),
    .rst   (rst),
    .start (sar_go),
    .cmp   (cmp_in),
    .busy  (sar_active),
    .done  (sar_done),
    .code  (sar_code),
    .dac   (dac_code)
  );

  assign conv_end = (st == ST_CONV) & sar_done;

  // completion flag
  always_ff @(posedge clk) begin
    if (rst)                    int_n <= 1'b1;
    else if (conv_end)          int_n <= 1'b0;
    else if (accept | rd_fall)  int_n <= 1'b1;
  end

  // result path
  adcseq_busport #(.W(DATA_W)) u_port (
    .clk     (clk),
    .rst     (rst),
    .load    (conv_end),
    .raw     (sar_code),
    .bip     (bip_q),
    .cs_s    (cs_s),
    .rd_s    (rd_s),
    .rd_fall (rd_fall),
    .data    (bus_out),
    .oe      (bus_oe)
  );

  assign trk_en       = (st == ST_TRK_INT) | (st == ST_TRK_EXT);
  assign ch_sel       = chan_q;
  assign bip_mode     = bip_q;
  assign rng_hi       = span_q;
  assign clk_internal = clk_int_q;
  assign standby      = pd_sel_q & ~pd_qual_q;
  assign full_pd      = pd_sel_q & pd_qual_q;

endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker
  import adcseq_pkg::*;
#(
  parameter int W   = 12,
  parameter int ACQ = 6
) (
  input logic         clk,
  input logic         rst,
  input seq_state_t   st,
  input logic         trk_en,
  input logic         sar_active,
  input logic [W-1:0] sar_mask,
  input logic         int_n
);

  int trk_cnt;
  int conv_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      trk_cnt  <= 0;
      conv_cnt <= 0;
    end else begin
      trk_cnt  <= trk_en ? trk_cnt + 1 : 0;
      conv_cnt <= sar_active ? conv_cnt + 1 : 0;
    end
  end

  AST_TRACK_CONV_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(trk_en && sar_active)); // R2

  AST_ACQ_LEN: assert property (@(posedge clk) disable iff (rst)
    ($rose(sar_active) && $past(st) == ST_TRK_INT) |-> trk_cnt == ACQ); // R2

  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sar_mask)); // R4

  AST_CONV_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(sar_active) |-> conv_cnt == W); // R4

  AST_INT_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(sar_active) |=> !int_n); // R6

endmodule

bind adcseq_top adcseq_checker #(.W(DATA_W), .ACQ(ACQ_CYCLES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .st         (st),
  .trk_en     (trk_en),
  .sar_active (sar_active),
  .sar_mask   (u_sar.mask),
  .int_n      (int_n)
);

// File: tb/adcseq_top_test.sv
`timescale 1ns/1ps
module adcseq_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0]  bus_in = 8'h00;
  logic        cmp_in;
  logic [11:0] bus_out, dac_code;
  logic        bus_oe, int_n, trk_en, sar_active;
  logic [2:0]  ch_sel;
  logic        bip_mode, rng_hi, clk_internal, standby, full_pd;
  logic [11:0] vin = 12'h000;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // comparator model: input at or above trial code
  assign cmp_in = (dac_code <= vin);

  adcseq_top uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .bus_in(bus_in), .cmp_in(cmp_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .int_n(int_n), .trk_en(trk_en), .sar_active(sar_active),
    .dac_code(dac_code), .ch_sel(ch_sel), .bip_mode(bip_mode),
    .rng_hi(rng_hi), .clk_internal(clk_internal), .standby(standby),
    .full_pd(full_pd)
  );

  // run-length monitors
  int trk_run = 0, trk_last = 0, sar_run = 0, sar_last = 0;
  always @(negedge clk) begin
    if (trk_en) trk_run++;
    else if (trk_run != 0) begin trk_last = trk_run; trk_run = 0; end
    if (sar_active) sar_run++;
    else if (sar_run != 0) begin sar_last = sar_run; sar_run = 0; end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] v, input logic sel);
    @(negedge clk);
    bus_in = v;
    cs_n = !sel;
    repeat (2) @(negedge clk);
    wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_read(input logic sel, output logic oe_seen, output logic [11:0] d);
    @(negedge clk);
    cs_n = !sel;
    repeat (2) @(negedge clk);
    rd_n = 1'b0;
    repeat (5) @(negedge clk);
    oe_seen = bus_oe;
    d = bus_out;
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_int(input string req);
    int n = 0;
    while (int_n && n < 200) begin @(negedge clk); n++; end
    chk(req, {15'd0, int_n}, 16'd0);
  endtask

  task automatic t_reset;
    chk("R12 int_n", {15'd0, int_n}, 16'd1);
    chk("R12 bus_oe", {15'd0, bus_oe}, 16'd0);
    chk("R12 trk_en", {15'd0, trk_en}, 16'd0);
    chk("R12 sar_active", {15'd0, sar_active}, 16'd0);
    chk("R12 ch_sel", {13'd0, ch_sel}, 16'd0);
    chk("R12 power", {13'd0, standby, full_pd, clk_internal}, 16'd0);
  endtask

  task automatic t_internal;
    logic oe; logic [11:0] d;
    vin = 12'hA5C;
    bus_write(8'h12, 1'b1); // span 1, unipolar, ch2
    chk("R1 ch_sel", {13'd0, ch_sel}, 16'd2);
    chk("R1 rng_hi/bip", {14'd0, rng_hi, bip_mode}, 16'b10);
    wait_int("R6 int low after conversion");
    chk("R2 track length", 16'(trk_last), 16'd6);
    chk("R4 conversion length", 16'(sar_last), 16'd12);
    bus_read(1'b1, oe, d);
    chk("R7 bus_oe during read", {15'd0, oe}, 16'd1);
    chk("R5 unipolar result", {4'd0, d}, 16'hA5C);
    chk("R7 bus_oe released", {15'd0, bus_oe}, 16'd0);
    chk("R6 int high after read", {15'd0, int_n}, 16'd1);
  endtask

  task automatic t_bipolar(input logic [7:0] ctl, input logic [11:0] v, input logic [11:0] exp);
    logic oe; logic [11:0] d;
    vin = v;
    bus_write(ctl, 1'b1);
    wait_int("R6 bipolar done");
    bus_read(1'b1, oe, d);
    chk("R5 coded result", {4'd0, d}, {4'd0, exp});
  endtask

  task automatic t_external;
    logic oe; logic [11:0] d;
    vin = 12'h3C3;
    bus_write(8'h24, 1'b1); // host-timed, ch4
    repeat (30) @(negedge clk);
    chk("R3 still tracking", {14'd0, trk_en, sar_active}, 16'b10);
    chk("R3 int stays high", {15'd0, int_n}, 16'd1);
    bus_write(8'h21, 1'b1); // host-timed again, ch1
    repeat (10) @(negedge clk);
    chk("R3 retrack on bit5=1", {13'd0, trk_en, ch_sel[1:0]}, 16'b101);
    bus_write(8'h03, 1'b1); // end acquisition, ch3
    chk("R3 ending write fields", {13'd0, ch_sel}, 16'd3);
    wait_int("R3 conversion after end write");
    bus_read(1'b1, oe, d);
    chk("R3 external result", {4'd0, d}, 16'h3C3);
  endtask

  task automatic t_busy_ignore;
    logic oe; logic [11:0] d;
    vin = 12'h555;
    bus_write(8'h00, 1'b1);
    bus_write(8'h0D, 1'b1); // ch5 bipolar, arrives mid-conversion
    wait_int("R11 first conversion done");
    chk("R11 channel kept", {13'd0, ch_sel}, 16'd0);
    bus_read(1'b1, oe, d);
    chk("R11 result of first byte", {4'd0, d}, 16'h555);
    repeat (30) @(negedge clk);
    chk("R11 no second conversion", {15'd0, int_n}, 16'd1);
  endtask

  task automatic t_cs_high;
    logic oe; logic [11:0] d;
    vin = 12'h0F0;
    bus_write(8'h01, 1'b1);
    wait_int("R8 setup conversion");
    bus_write(8'h05, 1'b0);
    repeat (8) @(negedge clk);
    chk("R8 write ignored ch", {13'd0, ch_sel}, 16'd1);
    chk("R8 write ignored trk/int", {14'd0, trk_en, int_n}, 16'd0);
    bus_read(1'b0, oe, d);
    chk("R8 read ignored oe", {15'd0, oe}, 16'd0);
    chk("R8 read ignored int", {15'd0, int_n}, 16'd0);
    bus_write(8'h06, 1'b1); // channel 6
    repeat (8) @(negedge clk);
    chk("R10 ch6 ignored", {12'd0, ch_sel, trk_en}, 16'b0010);
    chk("R10 int unchanged", {15'd0, int_n}, 16'd0);
    bus_write(8'h0F, 1'b1); // channel 7
    repeat (8) @(negedge clk);
    chk("R10 ch7 ignored", {12'd0, ch_sel, trk_en}, 16'b0010);
    bus_read(1'b1, oe, d);
    chk("R8 proper read", {3'd0, oe, d}, 16'h10F0);
  endtask

  task automatic t_power;
    logic oe; logic [11:0] d;
    vin = 12'h7E1;
    bus_write(8'h42, 1'b1); // normal, internal clock, ch2
    wait_int("R9 conversion in 01 mode");
    chk("R9 internal clock", {13'd0, clk_internal, standby, full_pd}, 16'b100);
    bus_write(8'h83, 1'b1); // standby, ch3
    repeat (10) @(negedge clk);
    chk("R9 standby", {13'd0, clk_internal, standby, full_pd}, 16'b110);
    chk("R9 no acquisition", {14'd0, trk_en, sar_active}, 16'd0);
    chk("R6 int high after write", {15'd0, int_n}, 16'd1);
    bus_write(8'hC0, 1'b1);
    repeat (10) @(negedge clk);
    chk("R9 full power-down", {13'd0, clk_internal, standby, full_pd}, 16'b101);
    chk("R9 no acquisition full", {14'd0, trk_en, sar_active}, 16'd0);
    bus_write(8'h00, 1'b1);
    wait_int("R9 normal ext clock conversion");
    chk("R9 external clock", {13'd0, clk_internal, standby, full_pd}, 16'b000);
    bus_read(1'b1, oe, d);
    chk("R9 result", {4'd0, d}, 16'h7E1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_internal();
    t_bipolar(8'h0B, 12'h123, 12'h923);
    t_bipolar(8'h18, 12'hFFF, 12'h7FF);
    t_bipolar(8'h04, 12'h000, 12'h000);
    t_external();
    t_busy_ignore();
    t_cs_high();
    t_power();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule